// File: doc/BRIEF.md
# Cascaded Interrupt Status Aggregator

This block gathers the interrupt sources of a network interface into one level-sensitive interrupt line. It has two levels. The top level holds a 32-bit status word and a 32-bit mask word. A 16-bit management sub-level holds its own status and mask. When the sub-level has any pending bit that its mask does not block, that pending state feeds one top-level status bit.

Single-cycle pulses from the datapath set individual top-level status bits. A link-state change fills the sub-level status. Software reaches all state through a simple 32-bit register port with valid, write, address and data. Reading either status register clears it. Two extra offsets are aliases of the top-level status and mask.

The interrupt output is a registered OR of every active source. Anything outside the register port, and the logic that produces the event pulses, belongs to the surrounding design.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, the top status and sub status read 0, the top mask reads 0xFF7FFFFF, the sub mask reads 0x0000FFFF, and `irq` is 0.
- R2: A one-cycle pulse sets one top status bit: `ev_rx_to_host` sets bit 16, `ev_rx_no_desc` sets bit 17, `ev_tx_fetch` sets bit 24 and `ev_tx_drained` sets bit 25. Each bit can then be read at offset 0x100.
- R3: A pulse on `ev_link_change` loads 0xFFFF into the sub status at offset 0x020.
- R4: In each cycle, `irq` takes the value computed from the register state of the cycle before. It is 1 when either of these holds:
  - a top status bit other than bit 23 is set while its top mask bit is 0;
  - a sub status bit is set while its sub mask bit (offset 0x024) is 0.
- R5: Top status bit 23 reads as 1 whenever the sub level has an unmasked pending bit. Top mask bit 23 has no effect on `irq`.
- R6: A read of offset 0x100 returns the full status. On the next edge it clears every stored bit except bit 23.
- R7: A read of offset 0x020 returns the sub status. On the next edge the sub status becomes 0.
- R8: An event that arrives in the same cycle as a clearing read is kept: the bit it sets is 1 after that edge.
- R9: Offset 0x108 behaves exactly like offset 0x100, read-to-clear included. Offset 0x10C behaves exactly like offset 0x104.
- R10: A write to any other word offset is stored, and a later read of that offset returns the stored value.
- R11: A write to the top status, top mask or sub mask stores the written word. A write to the sub status stores the low 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 9 | Byte offset of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational for the current address |
| ev_rx_to_host | input | 1 | Frame handed to host pulse |
| ev_rx_no_desc | input | 1 | No receive descriptor pulse |
| ev_tx_fetch | input | 1 | Transmit descriptor taken pulse |
| ev_tx_drained | input | 1 | Transmit queue empty pulse |
| ev_link_change | input | 1 | Link state change pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an event pulse landing on the same edge as a clearing read of the register it sets. Neither the event nor the read has a natural ordering against the other from outside, so the bench drives both in one cycle, and does so for both status levels. The cascade path is also exercised with the top mask fully set. This shows that only the sub mask gates bit 23. A behavioural model predicts every read value and the interrupt level on every clock.

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int ADDR_W        = 9,
  parameter int SUB_W         = 16,
  parameter int CASC_BIT      = 23,
  parameter int BIT_RX_HOST   = 16,
  parameter int BIT_RX_NODESC = 17,
  parameter int BIT_TX_FETCH  = 24,
  parameter int BIT_TX_DRAIN  = 25,
  parameter logic [31:0] TOP_MASK_RST = 32'hFF7F_FFFF,
  parameter logic [ADDR_W-1:0] A_TOP_STAT   = 'h100,
  parameter logic [ADDR_W-1:0] A_TOP_MASK   = 'h104,
  parameter logic [ADDR_W-1:0] A_STAT_ALIAS = 'h108,
  parameter logic [ADDR_W-1:0] A_MASK_ALIAS = 'h10C,
  parameter logic [ADDR_W-1:0] A_SUB_STAT   = 'h020,
  parameter logic [ADDR_W-1:0] A_SUB_MASK   = 'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_rx_to_host,
  input  logic              ev_rx_no_desc,
  input  logic              ev_tx_fetch,
  input  logic              ev_tx_drained,
  input  logic              ev_link_change,
  output logic              irq
);
  localparam int WORDS = 2 ** (ADDR_W - 2);
  localparam logic [31:0] CASC_ONE = 32'(1) << CASC_BIT;

  logic [31:0]       top_stat, top_mask, top_nxt, ev_vec, top_view;
  logic [SUB_W-1:0]  sub_stat, sub_mask, sub_nxt;
  logic [31:0]       scratch [WORDS];
  logic [ADDR_W-1:0] addr_c;
  logic              wr, rd, sub_pend, top_act;

  assign addr_c = (reg_addr == A_STAT_ALIAS) ? A_TOP_STAT :
                  (reg_addr == A_MASK_ALIAS) ? A_TOP_MASK : reg_addr;
  assign wr = reg_valid && reg_write;
  assign rd = reg_valid && !reg_write;

  assign sub_pend = |(sub_stat & ~sub_mask);
  assign top_act  = |(top_stat & ~top_mask & ~CASC_ONE);
  assign top_view = top_stat | (sub_pend ? CASC_ONE : 32'd0);

  always_comb begin
    ev_vec = '0;
    ev_vec[BIT_RX_HOST]   = ev_rx_to_host;
    ev_vec[BIT_RX_NODESC] = ev_rx_no_desc;
    ev_vec[BIT_TX_FETCH]  = ev_tx_fetch;
    ev_vec[BIT_TX_DRAIN]  = ev_tx_drained;
  end

  always_comb begin
    top_nxt = top_stat;
    if (wr && addr_c == A_TOP_STAT)      top_nxt = reg_wdata;
    else if (rd && addr_c == A_TOP_STAT) top_nxt = top_stat & CASC_ONE;
    top_nxt = top_nxt | ev_vec;

    sub_nxt = sub_stat;
    if (wr && addr_c == A_SUB_STAT)      sub_nxt = reg_wdata[SUB_W-1:0];
    else if (rd && addr_c == A_SUB_STAT) sub_nxt = '0;
    if (ev_link_change)                  sub_nxt = '1;
  end

  always_comb begin
    if (addr_c == A_TOP_STAT)      reg_rdata = top_view;
    else if (addr_c == A_TOP_MASK) reg_rdata = top_mask;
    else if (addr_c == A_SUB_STAT) reg_rdata = 32'(sub_stat);
    else if (addr_c == A_SUB_MASK) reg_rdata = 32'(sub_mask);
    else                           reg_rdata = scratch[addr_c[ADDR_W-1:2]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_stat <= '0;
      top_mask <= TOP_MASK_RST;
      sub_stat <= '0;
      sub_mask <= '1;
      irq      <= 1'b0;
      for (int i = 0; i < WORDS; i++) scratch[i] <= '0;
    end else begin
      top_stat <= top_nxt;
      sub_stat <= sub_nxt;
      irq      <= top_act || sub_pend;
      if (wr) begin
        if (addr_c == A_TOP_MASK)      top_mask <= reg_wdata;
        else if (addr_c == A_SUB_MASK) sub_mask <= reg_wdata[SUB_W-1:0];
        else if (addr_c != A_TOP_STAT && addr_c != A_SUB_STAT)
          scratch[addr_c[ADDR_W-1:2]] <= reg_wdata;
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
module irq_cascade_ctrl_chk #(
  parameter int ADDR_W        = 9,
  parameter int SUB_W         = 16,
  parameter int CASC_BIT      = 23,
  parameter int BIT_RX_HOST   = 16,
  parameter int BIT_RX_NODESC = 17,
  parameter logic [ADDR_W-1:0] A_TOP_STAT   = 'h100,
  parameter logic [ADDR_W-1:0] A_STAT_ALIAS = 'h108,
  parameter logic [ADDR_W-1:0] A_SUB_STAT   = 'h020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ev_rx_to_host,
  input logic              ev_rx_no_desc,
  input logic              ev_tx_fetch,
  input logic              ev_tx_drained,
  input logic              ev_link_change,
  input logic              irq,
  input logic [31:0]       top_stat,
  input logic [31:0]       top_mask,
  input logic [SUB_W-1:0]  sub_stat,
  input logic [SUB_W-1:0]  sub_mask
);
  localparam logic [31:0] CASC_ONE = 32'(1) << CASC_BIT;

  logic top_rd, sub_rd, any_ev, want;
  assign top_rd = reg_valid && !reg_write &&
                  (reg_addr == A_TOP_STAT || reg_addr == A_STAT_ALIAS);
  assign sub_rd = reg_valid && !reg_write && reg_addr == A_SUB_STAT;
  assign any_ev = ev_rx_to_host || ev_rx_no_desc || ev_tx_fetch || ev_tx_drained;
  assign want   = (|(top_stat & ~top_mask & ~CASC_ONE)) || (|(sub_stat & ~sub_mask));

  AST_IRQ_LAGS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(want)); // R4
  AST_RX_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_to_host |=> top_stat[BIT_RX_HOST]); // R2
  AST_LINK_FILLS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_change |=> sub_stat == '1); // R3
  AST_TOP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rd && !any_ev) |=> (top_stat & ~CASC_ONE) == 32'd0); // R6
  AST_SUB_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rd && !ev_link_change) |=> sub_stat == '0); // R7
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rd && ev_rx_no_desc) |=> top_stat[BIT_RX_NODESC]); // R8
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk #(
  .ADDR_W(ADDR_W), .SUB_W(SUB_W), .CASC_BIT(CASC_BIT),
  .BIT_RX_HOST(BIT_RX_HOST), .BIT_RX_NODESC(BIT_RX_NODESC),
  .A_TOP_STAT(A_TOP_STAT), .A_STAT_ALIAS(A_STAT_ALIAS), .A_SUB_STAT(A_SUB_STAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .ev_rx_to_host(ev_rx_to_host), .ev_rx_no_desc(ev_rx_no_desc),
  .ev_tx_fetch(ev_tx_fetch), .ev_tx_drained(ev_tx_drained),
  .ev_link_change(ev_link_change), .irq(irq), .top_stat(top_stat),
  .top_mask(top_mask), .sub_stat(sub_stat), .sub_mask(sub_mask)
);

// File: tb/irq_cascade_ctrl_tb.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
  localparam logic [31:0] CASC = 32'h0080_0000;

  logic clk = 0, rst_n = 0;
  logic b_valid = 0, b_write = 0;
  logic [8:0] b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [4:0] b_ev = '0;
  logic [31:0] rdata;
  logic irq;

  always #10 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(b_valid), .reg_write(b_write),
    .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(rdata),
    .ev_rx_to_host(b_ev[0]), .ev_rx_no_desc(b_ev[1]), .ev_tx_fetch(b_ev[2]),
    .ev_tx_drained(b_ev[3]), .ev_link_change(b_ev[4]), .irq(irq));

  logic [31:0] m_top, m_tmask;
  logic [15:0] m_sub, m_smask;
  logic [31:0] m_scr [128];
  logic m_irq;
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  function automatic logic [8:0] canon(input logic [8:0] a);
    if (a == 9'h108) return 9'h100;
    if (a == 9'h10C) return 9'h104;
    return a;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [8:0] a0);
    logic [8:0] a = canon(a0);
    logic pend = |(m_sub & ~m_smask);
    if (a == 9'h100) return m_top | (pend ? CASC : 32'd0);
    if (a == 9'h104) return m_tmask;
    if (a == 9'h020) return {16'd0, m_sub};
    if (a == 9'h024) return {16'd0, m_smask};
    return m_scr[a[8:2]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_top = 0; m_tmask = 32'hFF7F_FFFF; m_sub = 0; m_smask = 16'hFFFF; m_irq = 0;
      for (int i = 0; i < 128; i++) m_scr[i] = 0;
    end else begin
      logic [8:0] a;
      m_irq = (|(m_top & ~m_tmask & ~CASC)) || (|(m_sub & ~m_smask));
      a = canon(b_addr);
      if (b_valid && b_write) begin
        if (a == 9'h100) m_top = b_wdata;
        else if (a == 9'h104) m_tmask = b_wdata;
        else if (a == 9'h020) m_sub = b_wdata[15:0];
        else if (a == 9'h024) m_smask = b_wdata[15:0];
        else m_scr[a[8:2]] = b_wdata;
      end else if (b_valid) begin
        if (a == 9'h100) m_top = m_top & CASC;
        if (a == 9'h020) m_sub = 0;
      end
      if (b_ev[0]) m_top[16] = 1;
      if (b_ev[1]) m_top[17] = 1;
      if (b_ev[2]) m_top[24] = 1;
      if (b_ev[3]) m_top[25] = 1;
      if (b_ev[4]) m_sub = 16'hFFFF;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R4", "irq", {31'd0, irq}, {31'd0, m_irq});
    if (b_valid && !b_write) check(cur_req, "rdata", rdata, exp_rd(b_addr));
  end

  task automatic cyc(input logic v, input logic w, input logic [8:0] a,
                     input logic [31:0] d, input logic [4:0] e);
    @(posedge clk); #1;
    b_valid = v; b_write = w; b_addr = a; b_wdata = d; b_ev = e;
  endtask
  task automatic rd(input logic [8:0] a);                   cyc(1, 0, a, 0, 0); endtask
  task automatic wr(input logic [8:0] a, input logic [31:0] d); cyc(1, 1, a, d, 0); endtask
  task automatic ev(input logic [4:0] e);                   cyc(0, 0, 0, 0, e); endtask
  task automatic idle();                                    cyc(0, 0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; rd(9'h100); rd(9'h104); rd(9'h020); rd(9'h024); idle();
    cur_req = "R2"; ev(5'b00001); rd(9'h100); ev(5'b00010); rd(9'h100);
    ev(5'b00100); ev(5'b01000); rd(9'h100); rd(9'h100);
    cur_req = "R6"; ev(5'b01111); idle(); rd(9'h100); rd(9'h100);
    cur_req = "R4"; wr(9'h104, 32'hFFFE_FFFF); ev(5'b00001); idle(); idle();
    rd(9'h100); idle(); idle();
    cur_req = "R11"; wr(9'h100, 32'h0200_0F0F); idle(); idle(); rd(9'h100);
    wr(9'h104, 32'h1234_5678); rd(9'h104); wr(9'h024, 32'h0000_00F0); rd(9'h024);
    wr(9'h020, 32'hABCD_0010); idle(); rd(9'h020); idle();
    cur_req = "R3"; wr(9'h104, 32'hFFFF_FFFF); wr(9'h024, 32'hFFFF);
    ev(5'b10000); rd(9'h020); rd(9'h020);
    cur_req = "R5"; ev(5'b10000); wr(9'h024, 32'hFFFE); idle(); idle();
    rd(9'h100); rd(9'h100); wr(9'h104, 32'h0080_0000); idle(); idle();
    rd(9'h020); idle(); idle(); rd(9'h100);
    cur_req = "R8"; wr(9'h104, 32'hFF7F_FFFF); ev(5'b00010);
    cyc(1, 0, 9'h100, 0, 5'b00010); rd(9'h100); rd(9'h100);
    cyc(1, 0, 9'h020, 0, 5'b10000); rd(9'h020); rd(9'h020);
    cur_req = "R9"; ev(5'b00101); rd(9'h108); rd(9'h100);
    wr(9'h10C, 32'h0F0F_0000); rd(9'h104); rd(9'h10C);
    cur_req = "R10"; wr(9'h000, 32'hDEAD_BEEF); wr(9'h1FC, 32'h0123_4567);
    wr(9'h0C0, 32'hA5A5_5A5A); rd(9'h000); rd(9'h1FC); rd(9'h0C0); rd(9'h004);
    idle(); idle();
    finish_run();
  end
endmodule